// File: doc/BRIEF.md
# Supervisory reset and watchdog controller

This block drives the active-low reset line of a processor from a handful of digital fault inputs, all sampled on one system clock. The fault inputs are an undervoltage flag for the monitored rail, a supply-lockout flag, an active-low manual-reset button and a watchdog. Any fault pulls the reset line low. Once every fault has gone away, one shared timeout keeps the line low for a fixed number of cycles before it is released.

The manual-reset input and the watchdog kick input come from outside the clock domain. Each passes through a two-flop synchronizer. The synchronized manual-reset level then goes through a filter that rejects short low glitches. The watchdog counter is cleared by every rising and every falling edge of the kick input, and it is held at zero for as long as reset is asserted. A strap input selects one of two timeout values, and an enable input turns the watchdog off entirely. The supply-lockout flag acts on the output combinationally, so it needs no clock edge. The block's own power-on reset also produces one full release timeout.

Top module: `sup_reset_ctrl`

## Requirements
- R1: While `rst_n` is low, `rst_n_o` is 0. After `rst_n` rises, `rst_n_o` goes to 1 at the RST_CYC-th rising clock edge, provided no fault is present.
- R2: When `uv_i` is 1 at a clock edge, `rst_n_o` is 0 right after that edge. After `uv_i` returns to 0, `rst_n_o` goes to 1 at the RST_CYC-th clock edge that samples `uv_i` low.
- R3: `uvlo_i` = 1 forces `rst_n_o` to 0 in the same cycle, with no clock edge needed. After `uvlo_i` drops, the release follows the R2 timing.
- R4: A sustained low on `mr_n_i` asserts reset. After `mr_n_i` returns high, `rst_n_o` rises at the (RST_CYC+3)-th clock edge: two synchronizer stages, one filter stage, then the release timeout.
- R5: A low pulse on `mr_n_i` that lasts fewer than FILT_CYC clock edges has no effect on `rst_n_o`. A low pulse of FILT_CYC edges or more asserts reset.
- R6: Every change of `wd_kick_i`, whether rising or falling, clears the watchdog counter. Kicks spaced at most T edges apart never cause a reset. A spacing of T+1 edges does cause one. T is the selected timeout.
- R7: With the watchdog enabled and never kicked, `rst_n_o` stays 1 for T+1 sampled cycles after each release, then stays 0 for RST_CYC cycles.
- R8: The watchdog counter is held at zero for the whole time reset is asserted. After a fault that lasts longer than T, the first watchdog reset still comes T+1 cycles after the release.
- R9: With `wd_en_i` = 0, the watchdog never asserts reset.
- R10: `wd_sel_i` = 0 selects T = WD_TMO_A, and `wd_sel_i` = 1 selects T = WD_TMO_B.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low block reset, released synchronously upstream |
| uv_i | input | 1 | Monitored-rail undervoltage flag, 1 = fault |
| uvlo_i | input | 1 | Supply-lockout flag, 1 = supply too low |
| mr_n_i | input | 1 | Manual-reset input, active low, asynchronous |
| wd_kick_i | input | 1 | Watchdog kick; every edge clears the counter |
| wd_en_i | input | 1 | Watchdog enable, 1 = running |
| wd_sel_i | input | 1 | Timeout strap: 0 = WD_TMO_A, 1 = WD_TMO_B |
| rst_n_o | output | 1 | Active-low reset to the processor |

## Verification
The hardest situation to reach is the exact boundary between a kick that arrives in time and a watchdog bite. The kick is delayed by three flops before it clears the counter, and the counter's starting point depends on when reset was released. To fix that starting point, the bench first forces a release with a short undervoltage pulse. It then begins toggling the kick at the very next falling clock edge and sweeps the spacing across T-1, T and T+1. Holding the undervoltage fault for longer than T before a release shows that the counter was held rather than merely reset.

// File: rtl/sup_pkg.sv
package sup_pkg;
  typedef struct packed {
    logic uvlo;
    logic uv;
    logic man;
    logic wdog;
  } fault_t;
endpackage

// File: rtl/sup_sync.sv
module sup_sync #(
  parameter int W      = 2,
  parameter int STAGES = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  localparam int CW = STAGES * W;

  logic [CW-1:0] chain_q;
  logic [CW-1:0] chain_d;

  always_comb begin
    chain_d = {chain_q[CW-W-1:0], d};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= {STAGES{RST_VAL}};
    else        chain_q <= chain_d;
  end

  assign q = chain_q[CW-1 -: W];

  initial begin
    a_r4_sync_depth: assert (STAGES >= 2);
  end
endmodule

// File: rtl/sup_mr_filt.sv
module sup_mr_filt #(
  parameter int FILT_CYC = 10
) (
  input  logic clk,
  input  logic rst_n,
  input  logic mr_n_s,
  output logic mr_act
);
  localparam int CW = $clog2(FILT_CYC + 1);
  localparam logic [CW-1:0] LAST = CW'(FILT_CYC - 1);

  logic [CW-1:0] cnt_q, cnt_d;
  logic          act_q, act_d;
  logic          cnt_en;

  always_comb begin
    cnt_d  = cnt_q;
    act_d  = act_q;
    cnt_en = 1'b0;
    if (mr_n_s) begin
      cnt_d  = '0;
      act_d  = 1'b0;
      cnt_en = 1'b1;
    end else if (cnt_q == LAST) begin
      act_d  = 1'b1;
    end else begin
      cnt_d  = cnt_q + 1'b1;
      cnt_en = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      act_q <= 1'b0;
    end else begin
      if (cnt_en) cnt_q <= cnt_d;
      act_q <= act_d;
    end
  end

  assign mr_act = act_q;

  a_r5_release_on_high: assert property (@(posedge clk) disable iff (!rst_n)
    mr_n_s |=> !act_q);
  a_r5_set_needs_low: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(act_q) |-> $past(!mr_n_s));
endmodule

// File: rtl/sup_wdog.sv
module sup_wdog #(
  parameter int TMO_A = 1000,
  parameter int TMO_B = 4000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic kick_s,
  input  logic en,
  input  logic sel,
  input  logic hold,
  output logic bite
);
  localparam int TMO_MAX = (TMO_A > TMO_B) ? TMO_A : TMO_B;
  localparam int CW      = $clog2(TMO_MAX + 1);

  logic [CW-1:0] cnt_q, cnt_d;
  logic [CW-1:0] tmo;
  logic          kick_prev_q;
  logic          kick_edge;
  logic          clr;

  assign tmo       = sel ? CW'(TMO_B) : CW'(TMO_A);
  assign kick_edge = kick_s ^ kick_prev_q;
  assign bite      = en && !hold && (cnt_q >= tmo);
  assign clr       = hold || !en || kick_edge || bite;

  always_comb begin
    if (clr) cnt_d = '0;
    else     cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q       <= '0;
      kick_prev_q <= 1'b0;
    end else begin
      cnt_q       <= cnt_d;
      kick_prev_q <= kick_s;
    end
  end

  a_r8_hold_clears: assert property (@(posedge clk) disable iff (!rst_n)
    hold |=> (cnt_q == '0));
  a_r9_disable_clears: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> (cnt_q == '0));
  a_r6_kick_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (kick_s != kick_prev_q) |=> (cnt_q == '0));
  a_r7_bounded: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= CW'(TMO_MAX));
endmodule

// File: rtl/sup_stretch.sv
module sup_stretch
  import sup_pkg::*;
#(
  parameter int RST_CYC = 2000
) (
  input  logic   clk,
  input  logic   rst_n,
  input  fault_t fault,
  output logic   asserted
);
  localparam int CW = $clog2(RST_CYC + 1);
  localparam logic [CW-1:0] LAST = CW'(RST_CYC - 1);

  logic          any_fault;
  logic [CW-1:0] cnt_q, cnt_d;
  logic          asrt_q, asrt_d;

  assign any_fault = |fault;

  always_comb begin
    cnt_d  = cnt_q;
    asrt_d = asrt_q;
    if (any_fault) begin
      cnt_d  = '0;
      asrt_d = 1'b1;
    end else if (asrt_q) begin
      if (cnt_q == LAST) begin
        asrt_d = 1'b0;
        cnt_d  = '0;
      end else begin
        cnt_d  = cnt_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      asrt_q <= 1'b1;
    end else begin
      cnt_q  <= cnt_d;
      asrt_q <= asrt_d;
    end
  end

  assign asserted = asrt_q;

  a_r2_fault_asserts: assert property (@(posedge clk) disable iff (!rst_n)
    any_fault |=> asrt_q);
  a_r2_release_clean: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(asrt_q) |-> $past(!any_fault));
endmodule

// File: rtl/sup_reset_ctrl.sv
module sup_reset_ctrl
  import sup_pkg::*;
#(
  parameter int RST_CYC   = 20000,
  parameter int FILT_CYC  = 10,
  parameter int WD_TMO_A  = 1000000,
  parameter int WD_TMO_B  = 8000000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic uv_i,
  input  logic uvlo_i,
  input  logic mr_n_i,
  input  logic wd_kick_i,
  input  logic wd_en_i,
  input  logic wd_sel_i,
  output logic rst_n_o
);
  logic [1:0] raw_in, sync_out;
  logic       mr_n_s, kick_s;
  logic       mr_act, wd_bite, asserted;
  fault_t     fault;

  assign raw_in = {wd_kick_i, mr_n_i};

  sup_sync #(.W(2), .STAGES(2), .RST_VAL(2'b01)) u_sync (
    .clk(clk), .rst_n(rst_n), .d(raw_in), .q(sync_out)
  );

  assign mr_n_s = sync_out[0];
  assign kick_s = sync_out[1];

  sup_mr_filt #(.FILT_CYC(FILT_CYC)) u_filt (
    .clk(clk), .rst_n(rst_n), .mr_n_s(mr_n_s), .mr_act(mr_act)
  );

  sup_wdog #(.TMO_A(WD_TMO_A), .TMO_B(WD_TMO_B)) u_wdog (
    .clk(clk), .rst_n(rst_n), .kick_s(kick_s), .en(wd_en_i),
    .sel(wd_sel_i), .hold(asserted), .bite(wd_bite)
  );

  always_comb begin
    fault.uvlo = uvlo_i;
    fault.uv   = uv_i;
    fault.man  = mr_act;
    fault.wdog = wd_bite;
  end

  sup_stretch #(.RST_CYC(RST_CYC)) u_stretch (
    .clk(clk), .rst_n(rst_n), .fault(fault), .asserted(asserted)
  );

  assign rst_n_o = !asserted && !uvlo_i;

  a_r3_lockout_immediate: assert property (@(posedge clk) disable iff (!rst_n)
    uvlo_i |-> !rst_n_o);
  a_r2_uv_next_edge: assert property (@(posedge clk) disable iff (!rst_n)
    uv_i |=> !rst_n_o);
  a_r4_manual_holds: assert property (@(posedge clk) disable iff (!rst_n)
    mr_act |=> !rst_n_o);
endmodule

// File: tb/sup_reset_ctrl_test.sv
module sup_reset_ctrl_test;
  localparam int RST  = 16;
  localparam int FILT = 5;
  localparam int TA   = 24;
  localparam int TB   = 40;

  logic clk = 1'b0;
  logic rst_n, uv, uvlo, mr_n, kick, wd_en, wd_sel;
  logic rst_n_o;
  int   total = 0;
  int   bad   = 0;

  always #5 clk = ~clk;

  sup_reset_ctrl #(.RST_CYC(RST), .FILT_CYC(FILT), .WD_TMO_A(TA), .WD_TMO_B(TB)) uut (
    .clk(clk), .rst_n(rst_n), .uv_i(uv), .uvlo_i(uvlo), .mr_n_i(mr_n),
    .wd_kick_i(kick), .wd_en_i(wd_en), .wd_sel_i(wd_sel), .rst_n_o(rst_n_o)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic until_high(output int n);
    n = 0;
    do begin
      @(posedge clk); #1; n++;
    end while (!rst_n_o && n < 5000);
  endtask

  task automatic until_low(output int n);
    n = 0;
    do begin
      @(posedge clk); #1; n++;
    end while (rst_n_o && n < 5000);
  endtask

  task automatic fresh_release();
    int n;
    @(negedge clk); uv = 1'b1;
    @(negedge clk);
    @(negedge clk); uv = 1'b0;
    until_high(n);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog expired actual=0 expected=1");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    int n, h;
    bit low_seen;
    rst_n = 1'b0; uv = 1'b0; uvlo = 1'b0; mr_n = 1'b1;
    kick = 1'b0; wd_en = 1'b0; wd_sel = 1'b0;

    repeat (3) @(negedge clk);
    chk(rst_n_o == 1'b0, "R1 low in reset", rst_n_o, 0);
    rst_n = 1'b1;
    until_high(n);
    chk(n == RST, "R1 power-on release", n, RST);

    @(negedge clk); uv = 1'b1;
    @(posedge clk); #1;
    chk(rst_n_o == 1'b0, "R2 uv asserts", rst_n_o, 0);
    repeat (5) @(negedge clk);
    uv = 1'b0;
    until_high(n);
    chk(n == RST, "R2 uv release", n, RST);

    @(negedge clk); uvlo = 1'b1; #1;
    chk(rst_n_o == 1'b0, "R3 lockout immediate", rst_n_o, 0);
    repeat (4) @(negedge clk);
    uvlo = 1'b0;
    until_high(n);
    chk(n == RST, "R3 lockout release", n, RST);

    @(negedge clk); mr_n = 1'b0;
    repeat (10) @(negedge clk);
    chk(rst_n_o == 1'b0, "R4 manual asserts", rst_n_o, 0);
    mr_n = 1'b1;
    until_high(n);
    chk(n == RST + 3, "R4 manual release", n, RST + 3);

    for (int len = 1; len <= FILT + 2; len++) begin
      low_seen = 1'b0;
      for (int c = 0; c < len + RST + 8; c++) begin
        @(negedge clk);
        if (!rst_n_o) low_seen = 1'b1;
        mr_n = (c < len) ? 1'b0 : 1'b1;
      end
      chk(low_seen == (len >= FILT), $sformatf("R5 glitch len %0d", len),
          low_seen, (len >= FILT));
    end

    @(negedge clk); wd_en = 1'b1; wd_sel = 1'b0; uv = 1'b1;
    repeat (3 * TB) @(negedge clk);
    uv = 1'b0;
    until_high(n);
    chk(n == RST, "R8 release after long fault", n, RST);
    until_low(h);
    chk(h == TA + 1, "R8 first bite after hold", h, TA + 1);
    until_high(n);
    chk(n == RST, "R7 bite reset length", n, RST);
    until_low(h);
    chk(h == TA + 1, "R7 repeated bite", h, TA + 1);
    until_high(n);

    @(negedge clk); wd_sel = 1'b1; uv = 1'b1;
    repeat (3) @(negedge clk);
    uv = 1'b0;
    until_high(n);
    until_low(h);
    chk(h == TB + 1, "R10 strap selects B", h, TB + 1);
    until_high(n);
    @(negedge clk); wd_sel = 1'b0; uv = 1'b1;
    repeat (3) @(negedge clk);
    uv = 1'b0;
    until_high(n);
    until_low(h);
    chk(h == TA + 1, "R10 strap selects A", h, TA + 1);
    until_high(n);

    for (int k = TA - 1; k <= TA + 1; k++) begin
      fresh_release();
      low_seen = 1'b0;
      for (int c = 0; c < 6 * TA; c++) begin
        @(negedge clk);
        if (!rst_n_o) low_seen = 1'b1;
        if (c % k == 0) kick = ~kick;
      end
      chk(low_seen == (k > TA), $sformatf("R6 kick spacing %0d", k),
          low_seen, (k > TA));
      @(negedge clk); wd_en = 1'b0;
      repeat (RST + 4) @(negedge clk);
      if (!rst_n_o) until_high(n);
      @(negedge clk); wd_en = 1'b1;
      fresh_release();
    end

    @(negedge clk); wd_en = 1'b0;
    fresh_release();
    low_seen = 1'b0;
    for (int c = 0; c < 3 * TB; c++) begin
      @(negedge clk);
      if (!rst_n_o) low_seen = 1'b1;
    end
    chk(low_seen == 1'b0, "R9 disabled watchdog", low_seen, 0);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule